// File: doc/BRIEF.md
# Target/Period Alarm Comparator

This block watches one of two free-running 52-bit tick counters and raises an alarm when that count reaches a programmed point. It has two modes. In one-shot mode it fires once when the selected count is at or beyond an absolute target. In repeating mode it fires every N ticks, and the first alarm falls N ticks after the mode is entered.

Software writes the target and the period into shadow registers first. The target is written as a 20-bit upper word and a 32-bit lower word, and the period is 26 bits wide. The comparator only uses new values after a load strobe copies the shadow contents into the active registers. Each alarm produces a one-cycle event pulse for other logic to use as a trigger. It also sets a sticky raw flag, which is cleared by writing one. The interrupt output is the raw flag gated by an enable.

Top module: `alarm_cmp`

## Requirements
- R1: In one-shot mode (`mode_sel` = 0) with the comparator armed, the block fires in the first cycle the selected count is greater than or equal to the active target. `evt_pulse` goes high for exactly one cycle on the clock edge after the count value that triggered it is presented, and `raw_flag` sets on that same edge.
- R2: After a one-shot alarm, no further alarm occurs until a load strobe is given. Writes to the shadow target alone (`tgt_hi_we`, `tgt_lo_we`) neither arm the comparator nor change the active target.
- R3: A load strobe that makes active a target which the selected count has already passed fires on the second clock edge after the strobe is sampled.
- R4: While `work_en` is 0 no alarm is produced and a pending one-shot alarm is kept. When `work_en` returns to 1 with the count at or past the target, the alarm fires on the next edge.
- R5: `unit_sel` = 0 compares against `count_a` and `unit_sel` = 1 compares against `count_b`. A target reached only by the unselected counter produces no alarm.
- R6: In repeating mode (`mode_sel` = 1), arming happens on the edge where the mode bit is first seen as 1 after being 0. The first alarm point is the selected count at that edge plus the active period, and each later point is the previous point plus the active period.
- R7: A period load during repeating mode keeps the alarm point already scheduled and applies the new period from the next step on. Clearing the mode bit and setting it again re-arms the comparator from the current count with the active period.
- R8: Clearing the mode bit stops repeating alarms from the next edge on.
- R9: `raw_flag` is visible whatever the value of `int_ena`, and `irq` equals `raw_flag` AND `int_ena`.
- R10: `int_clr` = 1 for one cycle clears `raw_flag` on that edge. If an alarm fires on the same edge, the flag stays set.
- R11: After reset `evt_pulse`, `raw_flag` and `irq` are 0, and the comparator is disarmed in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_a | input | 52 | First counter value |
| count_b | input | 52 | Second counter value |
| unit_sel | input | 1 | 0 selects count_a, 1 selects count_b |
| work_en | input | 1 | Allows alarms to fire when 1 |
| mode_sel | input | 1 | 0 one-shot target mode, 1 repeating mode |
| tgt_hi_we | input | 1 | Write strobe for the shadow target upper word |
| tgt_hi_data | input | 20 | Shadow target bits 51..32 |
| tgt_lo_we | input | 1 | Write strobe for the shadow target lower word |
| tgt_lo_data | input | 32 | Shadow target bits 31..0 |
| per_we | input | 1 | Write strobe for the shadow period |
| per_data | input | 26 | Shadow period value |
| load_stb | input | 1 | Copies shadow target and period into the active registers and arms one-shot mode |
| int_ena | input | 1 | Interrupt enable |
| int_clr | input | 1 | Write-one clear of the raw flag |
| evt_pulse | output | 1 | One-cycle alarm event |
| raw_flag | output | 1 | Sticky raw alarm flag |
| irq | output | 1 | Raw flag gated by int_ena |

## Verification
Two kinds of internal error would be visible at the ports. A one-shot arm bit that stays set after firing would produce a second `evt_pulse` on the very next edge. A stale or miscomputed repeating alarm point would move the event away from the expected counter value, and that shows up at the first alarm after arming or after a period load. The scoreboard records the counter value expected at each event and compares it with the selected counter when the pulse appears. Any early, late, missing or extra pulse is therefore caught within one alarm interval. Faults in the flag logic show up one edge after a clear or a fire, as a `raw_flag` or `irq` value that disagrees with R9 and R10.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_REPEAT  = 1'b1
  } alarm_mode_e;

  localparam int unsigned LO_WORD_W = 32;
endpackage

// File: rtl/alarm_cmp_stage.sv
module alarm_cmp_stage #(
  parameter int unsigned CNT_W = 52,
  parameter int unsigned PER_W = 26,
  localparam int unsigned HI_W = CNT_W - alarm_cmp_pkg::LO_WORD_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                hi_we,
  input  logic [HI_W-1:0]                     hi_data,
  input  logic                                lo_we,
  input  logic [alarm_cmp_pkg::LO_WORD_W-1:0] lo_data,
  input  logic                                per_we,
  input  logic [PER_W-1:0]                    per_data,
  input  logic                                load_stb,
  output logic [CNT_W-1:0]                    tgt_act,
  output logic [PER_W-1:0]                    per_act
);
  localparam int unsigned LW = alarm_cmp_pkg::LO_WORD_W;

  logic [CNT_W-1:0] tgt_shd_q, tgt_shd_n;
  logic [PER_W-1:0] per_shd_q, per_shd_n;
  logic [CNT_W-1:0] tgt_act_q;
  logic [PER_W-1:0] per_act_q;
  logic             shd_en;

  // Shadow next state: each word is replaced independently of the other.
  always_comb begin
    tgt_shd_n = tgt_shd_q;
    per_shd_n = per_shd_q;
    if (hi_we)  tgt_shd_n[CNT_W-1:LW] = hi_data;
    if (lo_we)  tgt_shd_n[LW-1:0]     = lo_data;
    if (per_we) per_shd_n             = per_data;
  end

  assign shd_en = hi_we | lo_we | per_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_shd_q <= '0;
      per_shd_q <= '0;
    end else if (shd_en) begin
      tgt_shd_q <= tgt_shd_n;
      per_shd_q <= per_shd_n;
    end
  end

  // Active copy is taken from the shadow as it stood before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_act_q <= '0;
      per_act_q <= '0;
    end else if (load_stb) begin
      tgt_act_q <= tgt_shd_q;
      per_act_q <= per_shd_q;
    end
  end

  assign tgt_act = tgt_act_q;
  assign per_act = per_act_q;
endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 52,
  parameter int unsigned PER_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_a,
  input  logic [CNT_W-1:0] count_b,
  input  logic             unit_sel,
  input  logic             work_en,
  input  logic             mode_sel,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] tgt_act,
  input  logic [PER_W-1:0] per_act,
  output logic             fire
);
  localparam int unsigned PAD_W = CNT_W - PER_W;

  alarm_mode_e      mode, mode_q;
  logic             tgt_armed_q, tgt_armed_n;
  logic             rep_armed_q, rep_armed_n;
  logic [CNT_W-1:0] next_pt_q, next_pt_n;
  logic [CNT_W-1:0] cnt_sel, per_ext;
  logic             hit_tgt, hit_rep, rep_arm;
  logic             tgt_en, rep_en;

  assign mode    = alarm_mode_e'(mode_sel);
  assign cnt_sel = unit_sel ? count_b : count_a;
  assign per_ext = {{PAD_W{1'b0}}, per_act};
  assign rep_arm = (mode == MODE_REPEAT) && (mode_q == MODE_ONESHOT);

  assign hit_tgt = work_en && (mode == MODE_ONESHOT) && tgt_armed_q &&
                   (cnt_sel >= tgt_act);
  assign hit_rep = work_en && (mode == MODE_REPEAT) && rep_armed_q &&
                   !rep_arm && (cnt_sel >= next_pt_q);
  assign fire    = hit_tgt | hit_rep;

  always_comb begin
    tgt_armed_n = tgt_armed_q;
    if (load_stb)     tgt_armed_n = 1'b1;
    else if (hit_tgt) tgt_armed_n = 1'b0;
  end
  assign tgt_en = load_stb | hit_tgt;

  always_comb begin
    rep_armed_n = rep_armed_q;
    next_pt_n   = next_pt_q;
    if (mode != MODE_REPEAT) begin
      rep_armed_n = 1'b0;
    end else if (rep_arm) begin
      rep_armed_n = 1'b1;
      next_pt_n   = cnt_sel + per_ext;
    end else if (hit_rep) begin
      next_pt_n   = next_pt_q + per_ext;
    end
  end
  assign rep_en = (mode != MODE_REPEAT) | rep_arm | hit_rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ONESHOT;
    end else begin
      mode_q <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_armed_q <= 1'b0;
    end else if (tgt_en) begin
      tgt_armed_q <= tgt_armed_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_armed_q <= 1'b0;
      next_pt_q   <= '0;
    end else if (rep_en) begin
      rep_armed_q <= rep_armed_n;
      next_pt_q   <= next_pt_n;
    end
  end
endmodule

// File: rtl/alarm_cmp_flag.sv
module alarm_cmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic int_clr,
  input  logic int_ena,
  output logic evt_pulse,
  output logic raw_flag,
  output logic irq
);
  logic evt_q;
  logic raw_q, raw_n;
  logic raw_en;

  // A fire on the same edge overrides the clear.
  always_comb begin
    raw_n = raw_q;
    if (fire)         raw_n = 1'b1;
    else if (int_clr) raw_n = 1'b0;
  end
  assign raw_en = fire | int_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (raw_en) begin
      raw_q <= raw_n;
    end
  end

  assign evt_pulse = evt_q;
  assign raw_flag  = raw_q;
  assign irq       = raw_q & int_ena;
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int unsigned CNT_W = 52,
  parameter int unsigned PER_W = 26,
  localparam int unsigned HI_W = CNT_W - alarm_cmp_pkg::LO_WORD_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [CNT_W-1:0]                    count_a,
  input  logic [CNT_W-1:0]                    count_b,
  input  logic                                unit_sel,
  input  logic                                work_en,
  input  logic                                mode_sel,
  input  logic                                tgt_hi_we,
  input  logic [HI_W-1:0]                     tgt_hi_data,
  input  logic                                tgt_lo_we,
  input  logic [alarm_cmp_pkg::LO_WORD_W-1:0] tgt_lo_data,
  input  logic                                per_we,
  input  logic [PER_W-1:0]                    per_data,
  input  logic                                load_stb,
  input  logic                                int_ena,
  input  logic                                int_clr,
  output logic                                evt_pulse,
  output logic                                raw_flag,
  output logic                                irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_sync;
  logic [CNT_W-1:0] tgt_act;
  logic [PER_W-1:0] per_act;
  logic             fire;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  alarm_cmp_stage #(.CNT_W(CNT_W), .PER_W(PER_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .hi_we    (tgt_hi_we),
    .hi_data  (tgt_hi_data),
    .lo_we    (tgt_lo_we),
    .lo_data  (tgt_lo_data),
    .per_we   (per_we),
    .per_data (per_data),
    .load_stb (load_stb),
    .tgt_act  (tgt_act),
    .per_act  (per_act)
  );

  alarm_cmp_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .count_a  (count_a),
    .count_b  (count_b),
    .unit_sel (unit_sel),
    .work_en  (work_en),
    .mode_sel (mode_sel),
    .load_stb (load_stb),
    .tgt_act  (tgt_act),
    .per_act  (per_act),
    .fire     (fire)
  );

  alarm_cmp_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .fire      (fire),
    .int_clr   (int_clr),
    .int_ena   (int_ena),
    .evt_pulse (evt_pulse),
    .raw_flag  (raw_flag),
    .irq       (irq)
  );
endmodule

// File: rtl/alarm_cmp_check.sv
module alarm_cmp_check (
  input logic clk,
  input logic rst_n,
  input logic work_en,
  input logic int_clr,
  input logic int_ena,
  input logic evt_pulse,
  input logic raw_flag,
  input logic irq
);
  // R1: every event leaves the raw flag set
  assert_evt_sets_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> raw_flag);

  // R1: the raw flag only rises together with an event
  assert_raw_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_flag) |-> evt_pulse);

  // R4: no event follows a cycle with the work enable low
  assert_idle_no_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !work_en |=> !evt_pulse);

  // R9: the interrupt output never rises while disabled
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ena |-> !irq);

  // R10: a clear without a simultaneous fire empties the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(int_clr) && !evt_pulse |-> !raw_flag);

  // R10: the flag is sticky until cleared
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    raw_flag && !int_clr |=> raw_flag);
endmodule

bind alarm_cmp alarm_cmp_check u_check (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .work_en   (work_en),
  .int_clr   (int_clr),
  .int_ena   (int_ena),
  .evt_pulse (evt_pulse),
  .raw_flag  (raw_flag),
  .irq       (irq)
);

// File: tb/alarm_cmp_test.sv
module alarm_cmp_test;
  localparam int CNT_W = 52;
  localparam int PER_W = 26;
  localparam int HI_W  = CNT_W - 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [CNT_W-1:0] count_a, count_b;
  logic             unit_sel, work_en, mode_sel;
  logic             tgt_hi_we, tgt_lo_we, per_we, load_stb;
  logic [HI_W-1:0]  tgt_hi_data;
  logic [31:0]      tgt_lo_data;
  logic [PER_W-1:0] per_data;
  logic             int_ena, int_clr;
  logic             evt_pulse, raw_flag, irq;

  alarm_cmp #(.CNT_W(CNT_W), .PER_W(PER_W)) uut (
    .clk(clk), .rst_n(rst_n), .count_a(count_a), .count_b(count_b),
    .unit_sel(unit_sel), .work_en(work_en), .mode_sel(mode_sel),
    .tgt_hi_we(tgt_hi_we), .tgt_hi_data(tgt_hi_data),
    .tgt_lo_we(tgt_lo_we), .tgt_lo_data(tgt_lo_data),
    .per_we(per_we), .per_data(per_data), .load_stb(load_stb),
    .int_ena(int_ena), .int_clr(int_clr),
    .evt_pulse(evt_pulse), .raw_flag(raw_flag), .irq(irq)
  );

  // Free-running tick counters feeding the comparator.
  always @(posedge clk) begin
    if (!rst_n) begin
      count_a <= '0;
      count_b <= 52'h8_0000_0000_0000;
    end else begin
      count_a <= count_a + 1'b1;
      count_b <= count_b + 1'b1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [CNT_W-1:0] exp_q[$];
  string            tag_q[$];

  task automatic check(input bit ok, input string req, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_evt(input logic [CNT_W-1:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // Monitor: pops an expected counter value at each event pulse.
  always begin : monitor
    logic [CNT_W-1:0] sel, e;
    string t;
    @(posedge clk);
    #1;
    if (rst_n && evt_pulse) begin
      sel = unit_sel ? count_b : count_a;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2: unexpected event, actual count %0h expected none", sel);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(sel == e, t, sel, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_a(input logic [CNT_W-1:0] v);
    while (count_a != v) @(negedge clk);
  endtask

  task automatic stage_target(input logic [CNT_W-1:0] v);
    tgt_hi_we = 1'b1; tgt_lo_we = 1'b1;
    tgt_hi_data = v[CNT_W-1:32]; tgt_lo_data = v[31:0];
    tick();
    tgt_hi_we = 1'b0; tgt_lo_we = 1'b0;
  endtask

  task automatic stage_period(input logic [PER_W-1:0] v);
    per_we = 1'b1; per_data = v;
    tick();
    per_we = 1'b0;
  endtask

  task automatic pulse_load();
    load_stb = 1'b1;
    tick();
    load_stb = 1'b0;
  endtask

  task automatic clear_flag(input string req);
    int_clr = 1'b1;
    tick();
    int_clr = 1'b0;
    check(raw_flag == 1'b0, req, raw_flag, 0);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog expired, actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [CNT_W-1:0] c, cb;
    rst_n = 1'b0;
    unit_sel = 1'b0; work_en = 1'b1; mode_sel = 1'b0;
    tgt_hi_we = 1'b0; tgt_lo_we = 1'b0; per_we = 1'b0; load_stb = 1'b0;
    tgt_hi_data = '0; tgt_lo_data = '0; per_data = '0;
    int_ena = 1'b0; int_clr = 1'b0;
    repeat (4) tick();
    // R11: outputs idle during reset
    check(evt_pulse == 1'b0 && raw_flag == 1'b0 && irq == 1'b0, "R11", {evt_pulse, raw_flag, irq}, 0);
    rst_n = 1'b1;
    repeat (20) tick();
    // R11: disarmed after reset, nothing fired
    check(raw_flag == 1'b0, "R11", raw_flag, 0);

    // R1: one-shot target in the future
    c = count_a;
    stage_target(c + 20);
    pulse_load();
    expect_evt(c + 21, "R1");
    repeat (40) tick();
    // R9: raw visible with enable low, irq gated
    check(raw_flag == 1'b1, "R9", raw_flag, 1);
    check(irq == 1'b0, "R9", irq, 0);
    int_ena = 1'b1;
    #1;
    check(irq == 1'b1, "R9", irq, 1);
    clear_flag("R10");
    #1;
    check(irq == 1'b0, "R9", irq, 0);

    // R2: shadow write without load does nothing
    c = count_a;
    stage_target(c + 10);
    repeat (30) tick();
    check(raw_flag == 1'b0, "R2", raw_flag, 0);
    // R3: loading a target already passed fires two edges later
    c = count_a;
    pulse_load();
    expect_evt(c + 2, "R3");
    repeat (10) tick();
    check(raw_flag == 1'b1, "R3", raw_flag, 1);
    clear_flag("R10");

    // R4: work enable low holds the alarm back
    work_en = 1'b0;
    c = count_a;
    stage_target(c + 5);
    pulse_load();
    repeat (20) tick();
    check(raw_flag == 1'b0, "R4", raw_flag, 0);
    c = count_a;
    expect_evt(c + 1, "R4");
    work_en = 1'b1;
    repeat (5) tick();
    check(raw_flag == 1'b1, "R4", raw_flag, 1);
    clear_flag("R10");

    // R5: target in second counter's range, first counter selected
    unit_sel = 1'b0;
    cb = count_b;
    stage_target(cb + 10);
    pulse_load();
    repeat (30) tick();
    check(raw_flag == 1'b0, "R5", raw_flag, 0);
    cb = count_b;
    expect_evt(cb + 1, "R5");
    unit_sel = 1'b1;
    repeat (3) tick();
    check(raw_flag == 1'b1, "R5", raw_flag, 1);
    repeat (3) tick();
    unit_sel = 1'b0;
    clear_flag("R10");

    // R6: repeating mode, period 7
    stage_period(26'd7);
    pulse_load();
    c = count_a;
    mode_sel = 1'b1;
    expect_evt(c + 8, "R6");
    expect_evt(c + 15, "R6");
    wait_a(c + 16);
    // R7: new period keeps scheduled point, then steps by 4
    stage_period(26'd4);
    pulse_load();
    expect_evt(c + 22, "R7");
    expect_evt(c + 26, "R7");
    wait_a(c + 27);
    // R8: clearing the mode bit stops alarms
    mode_sel = 1'b0;
    wait_a(c + 30);
    // R7: re-arm from current count
    mode_sel = 1'b1;
    expect_evt(c + 35, "R7");
    wait_a(c + 36);
    mode_sel = 1'b0;
    repeat (20) tick();
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    clear_flag("R10");

    // R10: fire and clear on the same edge, set wins
    c = count_a;
    stage_target(c + 10);
    pulse_load();
    expect_evt(c + 11, "R10");
    wait_a(c + 10);
    int_clr = 1'b1;
    tick();
    int_clr = 1'b0;
    check(raw_flag == 1'b1, "R10", raw_flag, 1);
    clear_flag("R10");
    repeat (10) tick();

    check(exp_q.size() == 0, "R1", exp_q.size(), 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule